// File: doc/BRIEF.md
# Event Return Unwinder

This block executes the return side of the core's event nesting scheme. It owns the pending-level register, a 16-bit vector with one bit per event priority level: bit 0 is emulation, bit 1 reset, bit 2 NMI, bit 3 exception and bit 4 the global interrupt disable flag. Bits 5 to 15 are the hardware-error, timer and general interrupt levels. A return request carries a kind: emulation, NMI, exception or interrupt. An interrupt return also carries the level it unwinds. The block checks that the request is legal at the current level and picks the matching saved return address from the four address inputs. It then produces the new program counter and updates the pending register.

The lowest bit of a saved return address marks a nested entry. When that bit is set, the level's pending bit survives the return. The same unit also reacts to the interrupt return register being saved to or restored from the stack, which opens or closes the global disable. It emits a strobe that asks the event logic to look again at latched events, and a strobe that marks a drop from supervisor to user mode. The event dispatch logic reports new entries through a bit-set input that is merged into the pending register. Vector fetch and the return-address register file sit outside the block.

Top module: `evt_return_unwinder`

## Requirements
- R1: After reset, `pend` is 0x0012 (reset level and global disable set) and every strobe output is low.
- R2: The current level is the lowest set bit of `pend`, ignoring bits 0 and 4; if none is set, the core is in user mode. Kind encoding on `ret_kind` is 0 emulation, 1 NMI, 2 exception, 3 interrupt. Emulation, NMI and exception returns are legal only at level 0, 2 and 3 respectively. An interrupt return is illegal at level 0, 2 or 3. An illegal return pulses `illegal_ret`, does not pulse `jump` and changes only `pend` bit 0.
- R3: Any return issued in user mode is illegal.
- R4: The target level is 0, 2 or 3 for the first three kinds and `ret_level` for interrupt returns. The return address is `addr_emu` for target 0, `addr_nmi` for target 2, `addr_exc` for target 3 and `addr_int` for every other target.
- R5: A legal return pulses `jump` with `new_pc` equal to the selected address with bit 0 forced to zero. When that address had bit 0 clear, the target's pending bit is cleared; otherwise it is kept.
- R6: A legal return to target level 1 or to any level of 5 or above clears `pend` bit 4. Returns to levels 0, 2 and 3 leave it alone.
- R7: Every non-aborted return clears `pend` bit 0, and the current level is determined with bit 0 already cleared.
- R8: `reti_save` clears `pend` bit 4 and pulses `recheck`; `reti_restore` sets `pend` bit 4. Both are ignored in a cycle with `ret_valid` high.
- R9: Every non-aborted return, legal or not, pulses `recheck`.
- R10: A legal return pulses `to_user` when no level among bits 1-3 and 5-15 remains pending after the return (before the entry merge of R12).
- R11: An interrupt return whose `ret_level` is 4 or 16 or more pulses `abort_ret`, leaves `pend` unchanged and raises no other strobe.
- R12: `enter_mask` is ORed into the pending register every cycle, after the effects of returns and save/restore.
- R13: All outputs are registered: the response to a request appears on the outputs one clock later, strobes last one cycle, and at most one of `jump`, `illegal_ret` and `abort_ret` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | Return request this cycle |
| ret_kind | input | 2 | Return kind: 0 emulation, 1 NMI, 2 exception, 3 interrupt |
| ret_level | input | 5 | Level unwound by an interrupt return |
| reti_save | input | 1 | Interrupt return register saved to stack |
| reti_restore | input | 1 | Interrupt return register restored from stack |
| enter_mask | input | 16 | Levels entered by the dispatch logic this cycle |
| addr_emu | input | 32 | Saved emulation return address |
| addr_nmi | input | 32 | Saved NMI return address |
| addr_exc | input | 32 | Saved exception return address |
| addr_int | input | 32 | Saved interrupt return address |
| new_pc | output | 32 | Program counter to resume at |
| jump | output | 1 | Strobe: new_pc is valid |
| illegal_ret | output | 1 | Strobe: request illegal-resource exception |
| abort_ret | output | 1 | Strobe: malformed return level |
| recheck | output | 1 | Strobe: re-evaluate latched events |
| to_user | output | 1 | Strobe: return dropped to user mode |
| pend | output | 16 | Pending-level register |

## Verification
The bench checks the nesting marker in both states. A design that ignored bit 0 would drop the pending bit of a nested level or jump to an odd address. It returns to level 6 while level 11 is active, and returns to level 2 with interrupt kind. A design that selected the address by kind instead of by level, or cleared the global disable for low levels, would show a wrong `new_pc` or a wrong bit 4. It issues an emulation return with bit 0 set and a higher level still active; this return must be refused, because the emulation bit is dropped before the level is taken. Further cases cover levels 4 and 20, a save that collides with a return, and an entry that collides with a return. These catch designs that corrupt state on abort, let save/restore override a return, or let a new entry hide the drop to user mode.

// File: rtl/evret_pkg.sv
package evret_pkg;

    typedef enum logic [1:0] {
        RK_EMU = 2'd0,
        RK_NMI = 2'd1,
        RK_EXC = 2'd2,
        RK_INT = 2'd3
    } ret_kind_e;

    // Fixed level positions the neighbouring event logic decodes
    localparam int LV_EMU   = 0;
    localparam int LV_RST   = 1;
    localparam int LV_NMI   = 2;
    localparam int LV_EXC   = 3;
    localparam int LV_GDIS  = 4;
    localparam int LV_HWERR = 5;

endpackage

// File: rtl/evret_level_finder.sv
module evret_level_finder #(
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = $clog2(NUM_LVL) + 1
) (
    input  logic [NUM_LVL-1:0] pend_i,
    output logic [LVL_W-1:0]   lvl_o,
    output logic               user_o
);
    import evret_pkg::*;

    localparam logic [NUM_LVL-1:0] KEEP =
        ~((NUM_LVL'(1) << LV_EMU) | (NUM_LVL'(1) << LV_GDIS));

    logic [NUM_LVL-1:0] masked;

    always_comb begin
        masked = pend_i & KEEP;
        lvl_o  = LVL_W'(NUM_LVL);
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (masked[i]) begin
                lvl_o = LVL_W'(i);
            end
        end
        user_o = ~|masked;
    end

endmodule

// File: rtl/evret_legal_check.sv
module evret_legal_check #(
    parameter int NUM_LVL  = 16,
    parameter int LVL_W    = $clog2(NUM_LVL) + 1,
    parameter int LVL_IN_W = 5
) (
    input  evret_pkg::ret_kind_e kind_i,
    input  logic [LVL_IN_W-1:0]  req_lvl_i,
    input  logic [LVL_W-1:0]     curr_i,
    input  logic                 user_i,
    output logic [LVL_IN_W-1:0]  tgt_o,
    output logic                 abort_o,
    output logic                 illegal_o
);
    import evret_pkg::*;

    logic at_emu, at_nmi, at_exc;

    always_comb begin
        at_emu = (curr_i == LVL_W'(LV_EMU));
        at_nmi = (curr_i == LVL_W'(LV_NMI));
        at_exc = (curr_i == LVL_W'(LV_EXC));

        unique case (kind_i)
            RK_EMU:  tgt_o = LVL_IN_W'(LV_EMU);
            RK_NMI:  tgt_o = LVL_IN_W'(LV_NMI);
            RK_EXC:  tgt_o = LVL_IN_W'(LV_EXC);
            default: tgt_o = req_lvl_i;
        endcase

        abort_o = (kind_i == RK_INT) &&
                  ((req_lvl_i == LVL_IN_W'(LV_GDIS)) ||
                   (req_lvl_i >= LVL_IN_W'(NUM_LVL)));

        illegal_o = user_i;
        unique case (kind_i)
            RK_EMU:  if (!at_emu) illegal_o = 1'b1;
            RK_NMI:  if (!at_nmi) illegal_o = 1'b1;
            RK_EXC:  if (!at_exc) illegal_o = 1'b1;
            default: if (at_emu || at_nmi || at_exc) illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/evret_addr_mux.sv
module evret_addr_mux #(
    parameter int ADDR_W   = 32,
    parameter int LVL_IN_W = 5
) (
    input  logic [LVL_IN_W-1:0] tgt_i,
    input  logic [ADDR_W-1:0]   emu_i,
    input  logic [ADDR_W-1:0]   nmi_i,
    input  logic [ADDR_W-1:0]   exc_i,
    input  logic [ADDR_W-1:0]   int_i,
    output logic [ADDR_W-1:0]   addr_o
);
    import evret_pkg::*;

    always_comb begin
        if (tgt_i == LVL_IN_W'(LV_EMU))      addr_o = emu_i;
        else if (tgt_i == LVL_IN_W'(LV_NMI)) addr_o = nmi_i;
        else if (tgt_i == LVL_IN_W'(LV_EXC)) addr_o = exc_i;
        else                                 addr_o = int_i;
    end

endmodule

// File: rtl/evt_return_unwinder.sv
module evt_return_unwinder #(
    parameter int ADDR_W   = 32,
    parameter int NUM_LVL  = 16,
    parameter int LVL_IN_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ret_valid,
    input  logic [1:0]          ret_kind,
    input  logic [LVL_IN_W-1:0] ret_level,
    input  logic                reti_save,
    input  logic                reti_restore,
    input  logic [NUM_LVL-1:0]  enter_mask,
    input  logic [ADDR_W-1:0]   addr_emu,
    input  logic [ADDR_W-1:0]   addr_nmi,
    input  logic [ADDR_W-1:0]   addr_exc,
    input  logic [ADDR_W-1:0]   addr_int,
    output logic [ADDR_W-1:0]   new_pc,
    output logic                jump,
    output logic                illegal_ret,
    output logic                abort_ret,
    output logic                recheck,
    output logic                to_user,
    output logic [NUM_LVL-1:0]  pend
);
    import evret_pkg::*;

    localparam int LVL_W = $clog2(NUM_LVL) + 1;
    localparam logic [NUM_LVL-1:0] EMU_BIT  = NUM_LVL'(1) << LV_EMU;
    localparam logic [NUM_LVL-1:0] GDIS_BIT = NUM_LVL'(1) << LV_GDIS;
    localparam logic [NUM_LVL-1:0] RST_VAL  = (NUM_LVL'(1) << LV_RST) | GDIS_BIT;

    typedef struct packed {
        logic [NUM_LVL-1:0] pend;
        logic [ADDR_W-1:0]  pc;
        logic               jump;
        logic               illegal;
        logic               abort;
        logic               recheck;
        logic               to_user;
    } st_t;

    st_t st_d, st_q;

    ret_kind_e           kind;
    logic [NUM_LVL-1:0]  pend_noemu;
    logic [LVL_W-1:0]    curr_lvl;
    logic                in_user;
    logic [LVL_IN_W-1:0] tgt_lvl;
    logic                req_abort;
    logic                req_illegal;
    logic [ADDR_W-1:0]   sel_addr;

    assign kind       = ret_kind_e'(ret_kind);
    // The emulation bit is dropped before the level is taken (R7)
    assign pend_noemu = st_q.pend & ~EMU_BIT;

    evret_level_finder #(
        .NUM_LVL (NUM_LVL),
        .LVL_W   (LVL_W)
    ) u_find (
        .pend_i (pend_noemu),
        .lvl_o  (curr_lvl),
        .user_o (in_user)
    );

    evret_legal_check #(
        .NUM_LVL  (NUM_LVL),
        .LVL_W    (LVL_W),
        .LVL_IN_W (LVL_IN_W)
    ) u_legal (
        .kind_i    (kind),
        .req_lvl_i (ret_level),
        .curr_i    (curr_lvl),
        .user_i    (in_user),
        .tgt_o     (tgt_lvl),
        .abort_o   (req_abort),
        .illegal_o (req_illegal)
    );

    evret_addr_mux #(
        .ADDR_W   (ADDR_W),
        .LVL_IN_W (LVL_IN_W)
    ) u_mux (
        .tgt_i  (tgt_lvl),
        .emu_i  (addr_emu),
        .nmi_i  (addr_nmi),
        .exc_i  (addr_exc),
        .int_i  (addr_int),
        .addr_o (sel_addr)
    );

    logic [NUM_LVL-1:0] nxt;

    always_comb begin
        st_d         = st_q;
        st_d.jump    = 1'b0;
        st_d.illegal = 1'b0;
        st_d.abort   = 1'b0;
        st_d.recheck = 1'b0;
        st_d.to_user = 1'b0;
        nxt          = st_q.pend;

        if (ret_valid) begin
            if (req_abort) begin
                st_d.abort = 1'b1;
            end else begin
                nxt          = pend_noemu;
                st_d.recheck = 1'b1;
                if (req_illegal) begin
                    st_d.illegal = 1'b1;
                end else begin
                    st_d.jump = 1'b1;
                    st_d.pc   = {sel_addr[ADDR_W-1:1], 1'b0};
                    if (!sel_addr[0]) begin
                        for (int i = 0; i < NUM_LVL; i++) begin
                            if (tgt_lvl == LVL_IN_W'(i)) nxt[i] = 1'b0;
                        end
                    end
                    if (tgt_lvl >= LVL_IN_W'(LV_HWERR) ||
                        tgt_lvl == LVL_IN_W'(LV_RST)) begin
                        nxt = nxt & ~GDIS_BIT;
                    end
                    st_d.to_user = ~|(nxt & ~(EMU_BIT | GDIS_BIT));
                end
            end
        end else if (reti_save) begin
            nxt          = nxt & ~GDIS_BIT;
            st_d.recheck = 1'b1;
        end else if (reti_restore) begin
            nxt = nxt | GDIS_BIT;
        end

        st_d.pend = nxt | enter_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.pend    <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign new_pc      = st_q.pc;
    assign jump        = st_q.jump;
    assign illegal_ret = st_q.illegal;
    assign abort_ret   = st_q.abort;
    assign recheck     = st_q.recheck;
    assign to_user     = st_q.to_user;
    assign pend        = st_q.pend;

endmodule

// File: rtl/evret_checker.sv
module evret_checker #(
    parameter int ADDR_W  = 32,
    parameter int NUM_LVL = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ret_valid,
    input logic               reti_restore,
    input logic [NUM_LVL-1:0] enter_mask,
    input logic [ADDR_W-1:0]  new_pc,
    input logic               jump,
    input logic               illegal_ret,
    input logic               abort_ret,
    input logic               recheck,
    input logic               to_user,
    input logic [NUM_LVL-1:0] pend
);
    localparam int GDIS = 4;

    // R13: one outcome per request
    a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jump, illegal_ret, abort_ret}));

    // R5: resume address is always even
    a_r5_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        jump |-> !new_pc[0]);

    // R9: every served return requests a re-check
    a_r9_recheck: assert property (@(posedge clk) disable iff (!rst_n)
        (jump || illegal_ret) |-> recheck);

    // R10: user drop only on a taken return
    a_r10_user_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
        to_user |-> jump);

    // R11: aborted request leaves the pending register alone
    a_r11_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_ret && $past(enter_mask) == '0) |-> (pend == $past(pend)));

    // R11: aborted request raises no re-check
    a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort_ret |-> !recheck);

    // R7: emulation bit gone after any served return
    a_r7_emu_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((jump || illegal_ret) && !$past(enter_mask[0])) |-> !pend[0]);

    // R8: a lone restore closes the global disable
    a_r8_restore_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reti_restore) && !$past(ret_valid)) |-> pend[GDIS]);

endmodule

bind evt_return_unwinder evret_checker #(
    .ADDR_W  (ADDR_W),
    .NUM_LVL (NUM_LVL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_valid    (ret_valid),
    .reti_restore (reti_restore),
    .enter_mask   (enter_mask),
    .new_pc       (new_pc),
    .jump         (jump),
    .illegal_ret  (illegal_ret),
    .abort_ret    (abort_ret),
    .recheck      (recheck),
    .to_user      (to_user),
    .pend         (pend)
);

// File: tb/sim_evt_return_unwinder.sv
`timescale 1ns/1ps
module sim_evt_return_unwinder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_kind = 2'd0;
    logic [4:0]  ret_level = 5'd0;
    logic        reti_save = 1'b0;
    logic        reti_restore = 1'b0;
    logic [15:0] enter_mask = 16'h0;
    logic [31:0] addr_emu = 32'h0A00;
    logic [31:0] addr_nmi = 32'h0500;
    logic [31:0] addr_exc = 32'h0400;
    logic [31:0] addr_int = 32'h0;
    logic [31:0] new_pc;
    logic        jump, illegal_ret, abort_ret, recheck, to_user;
    logic [15:0] pend;

    always #5 clk = ~clk;

    evt_return_unwinder u0 (
        .clk (clk), .rst_n (rst_n), .ret_valid (ret_valid), .ret_kind (ret_kind),
        .ret_level (ret_level), .reti_save (reti_save), .reti_restore (reti_restore),
        .enter_mask (enter_mask), .addr_emu (addr_emu), .addr_nmi (addr_nmi),
        .addr_exc (addr_exc), .addr_int (addr_int), .new_pc (new_pc), .jump (jump),
        .illegal_ret (illegal_ret), .abort_ret (abort_ret), .recheck (recheck),
        .to_user (to_user), .pend (pend)
    );

    typedef struct {
        logic [31:0] pc;
        logic        j, ill, ab, rc, tu;
        logic [15:0] pnd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    localparam logic [1:0] K_EMU = 2'd0, K_NMI = 2'd1, K_EXC = 2'd2, K_INT = 2'd3;

    // Driver: apply one stimulus cycle, queue what must appear one clock later
    task automatic send(input logic rv, input logic [1:0] k, input logic [4:0] lv,
                        input logic sv, input logic rs, input logic [15:0] en,
                        input logic [31:0] epc, input logic ej, input logic eill,
                        input logic eab, input logic erc, input logic etu,
                        input logic [15:0] epnd, input string tag);
        exp_t e;
        @(negedge clk);
        ret_valid = rv; ret_kind = k; ret_level = lv;
        reti_save = sv; reti_restore = rs; enter_mask = en;
        @(posedge clk);
        e.pc = epc; e.j = ej; e.ill = eill; e.ab = eab; e.rc = erc; e.tu = etu;
        e.pnd = epnd; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        ret_valid = 1'b0; reti_save = 1'b0; reti_restore = 1'b0; enter_mask = '0;
    endtask

    // Monitor: compare the outputs against the oldest queued expectation
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (jump !== e.j || illegal_ret !== e.ill || abort_ret !== e.ab ||
                recheck !== e.rc || to_user !== e.tu || pend !== e.pnd ||
                (e.j && new_pc !== e.pc)) begin
                n_fail++;
                $display("FAIL %s: got j=%b ill=%b ab=%b rc=%b tu=%b pend=%h pc=%h exp j=%b ill=%b ab=%b rc=%b tu=%b pend=%h pc=%h",
                         e.tag, jump, illegal_ret, abort_ret, recheck, to_user, pend, new_pc,
                         e.j, e.ill, e.ab, e.rc, e.tu, e.pnd, e.pc);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (pend !== 16'h0012 || jump || illegal_ret || abort_ret || recheck || to_user) begin
            n_fail++;
            $display("FAIL R1 reset: pend=%h strobes=%b%b%b%b%b exp pend=0012 strobes=00000",
                     pend, jump, illegal_ret, abort_ret, recheck, to_user);
        end

        addr_int = 32'h100;
        send(1, K_INT, 5'd1, 0, 0, 16'h0, 32'h100, 1, 0, 0, 1, 1, 16'h0000,
             "R4 R5 R6 R10 return from reset level");
        send(1, K_EXC, 5'd0, 0, 0, 16'h0, 32'h0, 0, 1, 0, 1, 0, 16'h0000,
             "R3 R9 return in user mode");
        send(0, K_EMU, 5'd0, 0, 0, 16'h0810, 32'h0, 0, 0, 0, 0, 0, 16'h0810,
             "R12 entry merge");
        send(0, K_EMU, 5'd0, 1, 0, 16'h0, 32'h0, 0, 0, 0, 1, 0, 16'h0800,
             "R8 save clears disable");
        send(0, K_EMU, 5'd0, 0, 1, 16'h0, 32'h0, 0, 0, 0, 0, 0, 16'h0810,
             "R8 restore sets disable");
        addr_int = 32'h201;
        send(1, K_INT, 5'd11, 0, 0, 16'h0, 32'h200, 1, 0, 0, 1, 0, 16'h0800,
             "R5 R6 nested marker keeps level");
        send(0, K_EMU, 5'd0, 0, 0, 16'h0010, 32'h0, 0, 0, 0, 0, 0, 16'h0810,
             "R12 set disable by entry");
        addr_int = 32'h300;
        send(1, K_INT, 5'd6, 0, 0, 16'h0, 32'h300, 1, 0, 0, 1, 0, 16'h0800,
             "R6 R4 level 6 below current");
        addr_int = 32'h600;
        send(1, K_INT, 5'd11, 0, 0, 16'h0, 32'h600, 1, 0, 0, 1, 1, 16'h0000,
             "R5 R10 last level unwound");
        send(0, K_EMU, 5'd0, 0, 0, 16'h0018, 32'h0, 0, 0, 0, 0, 0, 16'h0018,
             "R12 enter exception");
        send(1, K_EXC, 5'd0, 1, 0, 16'h0, 32'h400, 1, 0, 0, 1, 1, 16'h0010,
             "R6 R8 exception return keeps disable, save ignored");
        send(0, K_EMU, 5'd0, 0, 0, 16'h0804, 32'h0, 0, 0, 0, 0, 0, 16'h0814,
             "R12 enter NMI");
        send(1, K_INT, 5'd11, 0, 0, 16'h0, 32'h0, 0, 1, 0, 1, 0, 16'h0814,
             "R2 interrupt return at NMI level");
        send(1, K_EXC, 5'd0, 0, 0, 16'h0, 32'h0, 0, 1, 0, 1, 0, 16'h0814,
             "R2 exception return at NMI level");
        send(1, K_NMI, 5'd0, 0, 0, 16'h0, 32'h500, 1, 0, 0, 1, 0, 16'h0810,
             "R2 R4 R6 NMI return");
        send(0, K_EMU, 5'd0, 0, 0, 16'h0001, 32'h0, 0, 0, 0, 0, 0, 16'h0811,
             "R12 enter emulation");
        send(1, K_EMU, 5'd0, 0, 0, 16'h0, 32'h0, 0, 1, 0, 1, 0, 16'h0810,
             "R7 R2 emulation bit dropped first");
        send(1, K_INT, 5'd4, 0, 0, 16'h0, 32'h0, 0, 0, 1, 0, 0, 16'h0810,
             "R11 level 4 aborts");
        send(1, K_INT, 5'd20, 0, 0, 16'h0, 32'h0, 0, 0, 1, 0, 0, 16'h0810,
             "R11 level 20 aborts");
        addr_int = 32'h700;
        send(1, K_INT, 5'd2, 0, 0, 16'h0, 32'h500, 1, 0, 0, 1, 0, 16'h0810,
             "R4 R6 interrupt kind at level 2 uses NMI address");
        addr_int = 32'h800;
        send(1, K_INT, 5'd11, 0, 0, 16'h0020, 32'h800, 1, 0, 0, 1, 1, 16'h0020,
             "R12 R10 entry during return");
        send(0, K_EMU, 5'd0, 0, 0, 16'h0, 32'h0, 0, 0, 0, 0, 0, 16'h0020,
             "R13 strobes last one cycle");
        addr_int = 32'h901;
        send(1, K_INT, 5'd5, 0, 0, 16'h0, 32'h900, 1, 0, 0, 1, 0, 16'h0020,
             "R5 nested return at level 5");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang exp finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule